// File: doc/BRIEF.md
# Deep power-down sequencing controller

This block is the always-on state machine that takes a chip into its deepest power state and brings it back. Software arms the mode by setting an enable bit in a small power-control register. Entry then starts when the core signals a wait-for-interrupt event with its deep-sleep bit set, provided the internal oscillator power-down controls are all clear. While the chip is down, every functional pad is released to high impedance, the core regulator is asked to switch off, and only a dedicated wake-up pin is watched.

A falling edge on the wake-up pin whose low level lasts a programmable minimum number of always-on clock cycles turns the regulator back on. Once the core supply reports good, the block holds a full system reset for a programmable number of cycles and then returns to normal running. Five general-purpose retention registers and the power-control register are cleared only by power-on reset, so data stored before entry survives the trip. A sticky cause flag, which software clears by writing 1, records that the last reset came from a deep power-down wake-up. The external reset pin has effect only while running.

Top module: `dpd_seq_ctrl`

## Requirements
- R1: Register addresses 0 to 4 are read/write retention registers of DATA_W bits; address 5 is the power-control register with the enable at bit 0 (read/write) and the wake-up cause flag at bit 1 (read; writing 1 clears it); all other bits and addresses 6 and 7 read as zero and ignore writes.
- R2: Entry starts only on a cycle with wfi_i high, deep_sleep_i high, the enable bit 1 and osc_pd_i all zero; otherwise the block stays running with pads driven.
- R3: From the cycle after entry starts until the wake-up reset ends, pad_oe_o is 0; reg_on_o is 0 from entry until a qualified wake-up.
- R4: After entry the block waits for supply_good_i to go low before it watches the wake-up pin.
- R5: While running, a low rst_pin_ni drives sys_rst_o high in the same cycle; outside the running state rst_pin_ni has no effect on sys_rst_o.
- R6: A wake-up needs the synchronized pin seen high while powered down, then low for MIN_LOW_CYC consecutive cycles; a low pulse shorter than that leaves reg_on_o at 0.
- R7: On a qualified wake-up reg_on_o goes to 1; after supply_good_i is high, sys_rst_o is high for exactly RST_CYC cycles, then pad_oe_o returns to 1.
- R8: At the end of the wake-up reset the cause flag reads 1, while the retention registers and the enable bit keep their values from before entry.
- R9: Power-on reset (rst_ni low) clears the retention registers, the enable and the flag, and leaves the block running with pad_oe_o and reg_on_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on low-power clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | ADDR_W | Write address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_raddr_i | input | ADDR_W | Read address |
| reg_rdata_o | output | DATA_W | Read data, combinational |
| wfi_i | input | 1 | Wait-for-interrupt event from the core |
| deep_sleep_i | input | 1 | Core deep-sleep bit |
| osc_pd_i | input | OSC_PD_W | Internal oscillator power-down controls |
| wake_pin_i | input | 1 | Wake-up pin, asynchronous |
| rst_pin_ni | input | 1 | External reset pin, active low |
| supply_good_i | input | 1 | Core supply above power-on threshold |
| reg_on_o | output | 1 | Core regulator on request |
| pad_oe_o | output | 1 | Functional pad drive enable, 0 means high impedance |
| sys_rst_o | output | 1 | Full system reset, active high |

## Verification
The hardest situation to reach is the powered-down state with a pin pulse just one cycle short of the qualification length, together with a reset-pin assertion during that time, since it requires a full entry handshake first. The stimulus arms the enable through the register port, raises a one-cycle wait-for-interrupt event with deep sleep set, drops the supply-good input, then drives a short low pulse and a reset-pin pulse and confirms that neither the regulator request nor the system reset moves before a full-length pulse is applied.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_OFF   = 2'd2,
    ST_WAKE  = 2'd3
  } dpd_state_e;

  localparam int PCTL_EN_BIT   = 0;
  localparam int PCTL_FLAG_BIT = 1;
endpackage

// File: rtl/dpd_wake_filter.sv
module dpd_wake_filter #(
  parameter  int MIN_LOW_CYC = 13,
  localparam int CNT_W       = $clog2(MIN_LOW_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pin_i,
  output logic wake_o
);
  logic [1:0]       sync_q;
  logic             pin_s;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  assign pin_s  = sync_q[1];
  assign wake_o = en_i && armed_q && !pin_s && (cnt_q == CNT_W'(MIN_LOW_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], pin_i};
  end

  // arm on a high level, then count consecutive low cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (pin_s) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (wake_o) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dpd_pwr_regs.sv
module dpd_pwr_regs #(
  parameter int GP_N   = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              flag_set_i,
  output logic              en_o,
  output logic              flag_o
);
  import dpd_pkg::*;

  logic [DATA_W-1:0] gp_q [GP_N];
  logic              en_q, flag_q;
  logic              pctl_we;

  assign pctl_we = we_i && (waddr_i == ADDR_W'(GP_N));

  for (genvar g = 0; g < GP_N; g++) begin : g_gp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 gp_q[g] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(g)))    gp_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (pctl_we) en_q <= wdata_i[PCTL_EN_BIT];
      if (flag_set_i)                          flag_q <= 1'b1;
      else if (pctl_we && wdata_i[PCTL_FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < GP_N; i++) begin
      if (raddr_i == ADDR_W'(i)) rdata_o = gp_q[i];
    end
    if (raddr_i == ADDR_W'(GP_N)) begin
      rdata_o[PCTL_EN_BIT]   = en_q;
      rdata_o[PCTL_FLAG_BIT] = flag_q;
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/dpd_seq_ctrl.sv
module dpd_seq_ctrl #(
  parameter  int GP_N        = 5,
  parameter  int DATA_W      = 32,
  parameter  int OSC_PD_W    = 2,
  parameter  int MIN_LOW_CYC = 13,
  parameter  int RST_CYC     = 8,
  localparam int ADDR_W      = $clog2(GP_N + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_waddr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic [ADDR_W-1:0]   reg_raddr_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                wfi_i,
  input  logic                deep_sleep_i,
  input  logic [OSC_PD_W-1:0] osc_pd_i,
  input  logic                wake_pin_i,
  input  logic                rst_pin_ni,
  input  logic                supply_good_i,
  output logic                reg_on_o,
  output logic                pad_oe_o,
  output logic                sys_rst_o
);
  import dpd_pkg::*;

  localparam int RC_W = $clog2(RST_CYC + 1);

  dpd_state_e      state_q, state_d;
  logic            pg_seen_q;
  logic [RC_W-1:0] rcnt_q;
  logic            pctl_en, pctl_flag;
  logic            wake_hit;
  logic            entry_ok;
  logic            rst_done;

  dpd_pwr_regs #(.GP_N(GP_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .waddr_i    (reg_waddr_i),
    .wdata_i    (reg_wdata_i),
    .raddr_i    (reg_raddr_i),
    .rdata_o    (reg_rdata_o),
    .flag_set_i (rst_done),
    .en_o       (pctl_en),
    .flag_o     (pctl_flag)
  );

  dpd_wake_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_OFF),
    .pin_i  (wake_pin_i),
    .wake_o (wake_hit)
  );

  assign entry_ok = wfi_i && deep_sleep_i && pctl_en && (osc_pd_i == '0);
  assign rst_done = (state_q == ST_WAKE) && pg_seen_q && (rcnt_q == RC_W'(RST_CYC - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (entry_ok)       state_d = ST_ENTER;
      ST_ENTER: if (!supply_good_i) state_d = ST_OFF;
      ST_OFF:   if (wake_hit)       state_d = ST_WAKE;
      ST_WAKE:  if (rst_done)       state_d = ST_RUN;
      default:                      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      pg_seen_q <= 1'b0;
      rcnt_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_WAKE || rst_done) begin
        pg_seen_q <= 1'b0;
        rcnt_q    <= '0;
      end else if (!pg_seen_q) begin
        pg_seen_q <= supply_good_i;
      end else begin
        rcnt_q <= rcnt_q + 1'b1;
      end
    end
  end

  assign pad_oe_o  = (state_q == ST_RUN);
  assign reg_on_o  = (state_q == ST_RUN) || (state_q == ST_WAKE);
  assign sys_rst_o = ((state_q == ST_RUN) && !rst_pin_ni) || ((state_q == ST_WAKE) && pg_seen_q);
endmodule

// File: rtl/dpd_seq_chk.sv
module dpd_seq_chk #(
  parameter int OSC_PD_W = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input dpd_pkg::dpd_state_e state_i,
  input logic                pad_oe_i,
  input logic                reg_on_i,
  input logic                sys_rst_i,
  input logic                en_i,
  input logic                flag_i,
  input logic                wfi_i,
  input logic                deep_sleep_i,
  input logic [OSC_PD_W-1:0] osc_pd_i,
  input logic                wake_i,
  input logic                supply_good_i
);
  import dpd_pkg::*;

  // R2
  entry_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && !(wfi_i && deep_sleep_i && en_i && osc_pd_i == '0)) |=> (state_i == ST_RUN));

  // R3
  pads_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_RUN) |-> !pad_oe_i);

  // R3
  reg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OFF || state_i == ST_ENTER) |-> !reg_on_i);

  // R4
  supply_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ENTER && supply_good_i) |=> (state_i == ST_ENTER));

  // R5
  rst_pin_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OFF || state_i == ST_ENTER) |-> !sys_rst_i);

  // R6
  wake_only_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_OFF && !wake_i) |=> (state_i == ST_OFF));

  // R8
  flag_on_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAKE && sys_rst_i) ##1 (state_i == ST_RUN) |-> flag_i);
endmodule

bind dpd_seq_ctrl dpd_seq_chk #(.OSC_PD_W(OSC_PD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .state_i       (state_q),
  .pad_oe_i      (pad_oe_o),
  .reg_on_i      (reg_on_o),
  .sys_rst_i     (sys_rst_o),
  .en_i          (pctl_en),
  .flag_i        (pctl_flag),
  .wfi_i         (wfi_i),
  .deep_sleep_i  (deep_sleep_i),
  .osc_pd_i      (osc_pd_i),
  .wake_i        (wake_hit),
  .supply_good_i (supply_good_i)
);

// File: tb/sim_dpd_seq_ctrl.sv
`timescale 1ns/1ps
module sim_dpd_seq_ctrl;
  localparam int GP_N = 5, DATA_W = 32, OSC_PD_W = 2, MIN_LOW = 13, RST_CYC = 8;
  localparam int AW = $clog2(GP_N + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [AW-1:0] reg_waddr_i = '0, reg_raddr_i = '0;
  logic [DATA_W-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic wfi_i = 1'b0, deep_sleep_i = 1'b0;
  logic [OSC_PD_W-1:0] osc_pd_i = '0;
  logic wake_pin_i = 1'b1, rst_pin_ni = 1'b1, supply_good_i = 1'b1;
  logic reg_on_o, pad_oe_o, sys_rst_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk_i = ~clk_i;

  dpd_seq_ctrl #(.GP_N(GP_N), .DATA_W(DATA_W), .OSC_PD_W(OSC_PD_W),
                 .MIN_LOW_CYC(MIN_LOW), .RST_CYC(RST_CYC)) u0 (.*);

  typedef struct packed {
    logic [2:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 32'hA5A5_0001, 32'hA5A5_0001},
    '{3'd1, 32'h1234_5678, 32'h1234_5678},
    '{3'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{3'd3, 32'h0000_0000, 32'h0000_0000},
    '{3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{3'd5, 32'hFFFF_FFFF, 32'h0000_0001},
    '{3'd6, 32'h1111_1111, 32'h0000_0000},
    '{3'd5, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
    cyc++;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_waddr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    reg_raddr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic enter_dpd();
    deep_sleep_i = 1'b1; osc_pd_i = '0; wfi_i = 1'b1;
    tick();
    wfi_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R9 reset state
    chk("R9 pad_oe", 32'(pad_oe_o), 1);
    chk("R9 reg_on", 32'(reg_on_o), 1);
    chk("R9 sys_rst", 32'(sys_rst_o), 0);
    rd(3'd5, d); chk("R9 pctl", d, 0);

    // R1 register vectors
    foreach (VEC[i]) begin
      wr(VEC[i].a, VEC[i].w);
      rd(VEC[i].a, d);
      chk("R1 reg vector", d, VEC[i].e);
    end
    rd(3'd7, d); chk("R1 addr7", d, 0);

    // R5 reset pin while running
    rst_pin_ni = 1'b0; #1;
    chk("R5 pin in run", 32'(sys_rst_o), 1);
    rst_pin_ni = 1'b1; #1;
    chk("R5 pin release", 32'(sys_rst_o), 0);

    // R2 refused entries
    enter_dpd();
    chk("R2 enable off", 32'(pad_oe_o), 1);
    wr(3'd5, 32'h1);
    deep_sleep_i = 1'b1; osc_pd_i = 2'b01; wfi_i = 1'b1; tick(); wfi_i = 1'b0;
    chk("R2 osc pd set", 32'(pad_oe_o), 1);
    osc_pd_i = 2'b10; wfi_i = 1'b1; tick(); wfi_i = 1'b0;
    chk("R2 osc pd hi", 32'(pad_oe_o), 1);
    deep_sleep_i = 1'b0; osc_pd_i = '0; wfi_i = 1'b1; tick(); wfi_i = 1'b0;
    chk("R2 no deep sleep", 32'(pad_oe_o), 1);
    deep_sleep_i = 1'b1; tick();
    chk("R2 no wfi", 32'(pad_oe_o), 1);

    // R3 R4 entry
    enter_dpd();
    chk("R3 pads released", 32'(pad_oe_o), 0);
    chk("R3 reg off", 32'(reg_on_o), 0);
    wake_pin_i = 1'b0;
    repeat (2 * MIN_LOW) tick();
    chk("R4 pin ignored before supply low", 32'(reg_on_o), 0);
    wake_pin_i = 1'b1;
    supply_good_i = 1'b0;
    repeat (5) tick();

    // R5 ignored in off, R6 short pulse
    rst_pin_ni = 1'b0;
    wake_pin_i = 1'b0;
    repeat (MIN_LOW - 1) tick();
    chk("R5 pin ignored off", 32'(sys_rst_o), 0);
    wake_pin_i = 1'b1;
    rst_pin_ni = 1'b1;
    repeat (20) tick();
    chk("R6 short pulse", 32'(reg_on_o), 0);
    chk("R3 still released", 32'(pad_oe_o), 0);

    // R6 R7 qualified wake
    wake_pin_i = 1'b0;
    n = 0;
    while (!reg_on_o && n < 100) begin tick(); n++; end
    chk("R6 wake qualified", 32'(reg_on_o), 1);
    chk("R6 wake min length", 32'(n >= MIN_LOW), 1);
    wake_pin_i = 1'b1;
    chk("R7 no reset before supply", 32'(sys_rst_o), 0);
    repeat (3) tick();
    chk("R7 pads wait supply", 32'(pad_oe_o), 0);
    supply_good_i = 1'b1;
    tick();
    n = 0;
    while (sys_rst_o && n < 100) begin n++; tick(); end
    chk("R7 reset length", n, RST_CYC);
    chk("R7 pads back", 32'(pad_oe_o), 1);

    // R8 flag and retention
    rd(3'd5, d); chk("R8 flag and enable", d, 32'h3);
    rd(3'd1, d); chk("R8 gp1 kept", d, 32'h1234_5678);
    rd(3'd4, d); chk("R8 gp4 kept", d, 32'hFFFF_FFFF);
    wr(3'd5, 32'h1);
    rd(3'd5, d); chk("R1 flag write 0 keeps", d, 32'h3);
    wr(3'd5, 32'h2);
    rd(3'd5, d); chk("R1 flag clear", d, 32'h0);

    // R9 power-on reset clears retained state
    wr(3'd2, 32'h5555_AAAA);
    wr(3'd5, 32'h1);
    rst_ni = 1'b0; tick(); rst_ni = 1'b1; tick();
    rd(3'd2, d); chk("R9 gp cleared", d, 0);
    rd(3'd5, d); chk("R9 pctl cleared", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule